// File: doc/BRIEF.md
# Chip-Select-Gated Command Register

This block is the registered command/address stage of a buffered memory module. On every rising clock edge it captures a command/address bus, the rank chip selects and the clock-enable and on-die-termination control lines. It then drives each of them to two output sides, A and B, one cycle later. Each side feeds its own group of memory devices.

A configuration pin decides how the chip selects fan out. In dual mode, only the two low chip-select inputs are used, and each is copied to both sides. In quad mode, all four chip-select inputs are used, and each drives exactly one output: the low two go to side A and the high two go to side B. The pin is latched only while reset is held, so the mode stays fixed for the whole session.

The command/address outputs are loaded only when at least one chip select that counts in the current mode is asserted (low). In every other cycle they hold their value, which saves switching power on idle cycles. The clock-enable and termination lines are not gated by the chip selects. A synchronous reset puts every output into an idle state.

Top module: `csg_cmd_register`

## Requirements
- R1: Every registered output changes only at a rising clock edge, one cycle after its input is sampled; between edges the outputs do not follow the inputs.
- R2: When a counted chip select is low at a rising edge, `ca_a` and `ca_b` both take the value on `ca_in` at that edge.
- R3: Dual mode (`dual_mode_pin` = 1 during reset): `cs_n_in[0]` drives `cs_a_n[0]` and `cs_b_n[0]`, and `cs_n_in[1]` drives `cs_a_n[1]` and `cs_b_n[1]`. `cs_n_in[3:2]` has no effect on any output, and this includes command/address gating.
- R4: Quad mode (`dual_mode_pin` = 0 during reset): `cs_n_in[0]` drives `cs_a_n[0]`, `cs_n_in[1]` drives `cs_a_n[1]`, `cs_n_in[2]` drives `cs_b_n[0]`, and `cs_n_in[3]` drives `cs_b_n[1]`. Any of the four being low counts as a selection.
- R5: When no counted chip select is low at an edge, `ca_a` and `ca_b` keep their previous value.
- R6: One edge with `rst` high drives all chip-select outputs to 1 and all clock-enable, termination and command/address outputs to 0.
- R7: `cke_in` and `odt_in` are registered to both sides at every edge, whatever the chip selects are.
- R8: `dual_mode_pin` is sampled only while `rst` is high; changing it outside reset has no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dual_mode_pin | input | 1 | 1 = dual chip-select mode, 0 = quad mode; latched during reset |
| cs_n_in | input | 4 | Chip-select inputs, active low |
| ca_in | input | CA_W | Command/address bus |
| cke_in | input | CTL_W | Clock-enable lines |
| odt_in | input | CTL_W | On-die-termination lines |
| ca_a | output | CA_W | Command/address copy, side A |
| ca_b | output | CA_W | Command/address copy, side B |
| cs_a_n | output | 2 | Chip-select outputs, side A |
| cs_b_n | output | 2 | Chip-select outputs, side B |
| cke_a | output | CTL_W | Clock-enable copy, side A |
| cke_b | output | CTL_W | Clock-enable copy, side B |
| odt_a | output | CTL_W | Termination copy, side A |
| odt_b | output | CTL_W | Termination copy, side B |

## Verification
The bench builds the block with CA_W = 16 and CTL_W = 2. With a 16-bit bus, every command/address vector is a readable four-digit hex value, so a hold can be told apart from a load at a glance. With two control lines, the clock-enable and termination patterns can be walked through all their combinations within the vector table. Both chip-select modes are reached through a second reset. In dual mode, the vectors drive only the ignored upper chip selects low, which shows that they neither load the bus nor reach an output. In quad mode, the pin is toggled after reset to show that the latched mode does not change.

// File: rtl/csg_pkg.sv
package csg_pkg;
    localparam int CS_IN_W   = 4;
    localparam int CS_SIDE_W = CS_IN_W / 2;

    typedef enum logic {
        MODE_DUAL = 1'b0,
        MODE_QUAD = 1'b1
    } cs_mode_e;
endpackage

// File: rtl/csg_cs_router.sv
module csg_cs_router
    import csg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 dual_mode_pin,
    input  logic [CS_IN_W-1:0]   cs_n_in,
    output logic [CS_SIDE_W-1:0] cs_a_n_o,
    output logic [CS_SIDE_W-1:0] cs_b_n_o,
    output logic                 any_sel_o
);
    typedef struct packed {
        cs_mode_e             mode;
        logic [CS_SIDE_W-1:0] a_n;
        logic [CS_SIDE_W-1:0] b_n;
    } cs_state_t;

    cs_state_t st_d, st_q;
    logic [CS_SIDE_W-1:0] map_a_n, map_b_n;

    // Fan-out per chip-select position; the mode picks the variant.
    for (genvar i = 0; i < CS_SIDE_W; i++) begin : g_map
        assign map_a_n[i] = cs_n_in[i];
        assign map_b_n[i] = (st_q.mode == MODE_QUAD) ? cs_n_in[i + CS_SIDE_W] : cs_n_in[i];
    end

    assign any_sel_o = (st_q.mode == MODE_QUAD) ? ~(&cs_n_in)
                                                : ~(&cs_n_in[CS_SIDE_W-1:0]);

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.mode = dual_mode_pin ? MODE_DUAL : MODE_QUAD;
            st_d.a_n  = '1;
            st_d.b_n  = '1;
        end else begin
            st_d.a_n  = map_a_n;
            st_d.b_n  = map_b_n;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cs_a_n_o = st_q.a_n;
    assign cs_b_n_o = st_q.b_n;

    AST_CS_IDLE_RESET: assert property (@(posedge clk)
        rst |=> (&cs_a_n_o) && (&cs_b_n_o)); // R6

    AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(st_q.mode)); // R8

    AST_DUAL_FANOUT: assert property (@(posedge clk) disable iff (rst)
        (st_q.mode == MODE_DUAL) |=>
            cs_a_n_o == $past(cs_n_in[CS_SIDE_W-1:0]) &&
            cs_b_n_o == $past(cs_n_in[CS_SIDE_W-1:0])); // R3

    AST_QUAD_FANOUT: assert property (@(posedge clk) disable iff (rst)
        (st_q.mode == MODE_QUAD) |=>
            {cs_b_n_o, cs_a_n_o} == $past(cs_n_in)); // R4
endmodule

// File: rtl/csg_ca_stage.sv
module csg_ca_stage #(
    parameter int CA_W = 24
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [CA_W-1:0] ca_in,
    output logic [CA_W-1:0] ca_a_o,
    output logic [CA_W-1:0] ca_b_o
);
    typedef struct packed {
        logic [CA_W-1:0] a;
        logic [CA_W-1:0] b;
    } ca_state_t;

    ca_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.a = '0;
            st_d.b = '0;
        end else if (load) begin
            st_d.a = ca_in;
            st_d.b = ca_in;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign ca_a_o = st_q.a;
    assign ca_b_o = st_q.b;

    AST_CA_RESET: assert property (@(posedge clk)
        rst |=> ca_a_o == '0 && ca_b_o == '0); // R6

    AST_CA_LOAD: assert property (@(posedge clk) disable iff (rst)
        load |=> ca_a_o == $past(ca_in) && ca_b_o == $past(ca_in)); // R2

    AST_CA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(ca_a_o) && $stable(ca_b_o)); // R5
endmodule

// File: rtl/csg_ctl_stage.sv
module csg_ctl_stage #(
    parameter int CTL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CTL_W-1:0] cke_in,
    input  logic [CTL_W-1:0] odt_in,
    output logic [CTL_W-1:0] cke_a_o,
    output logic [CTL_W-1:0] cke_b_o,
    output logic [CTL_W-1:0] odt_a_o,
    output logic [CTL_W-1:0] odt_b_o
);
    typedef struct packed {
        logic [CTL_W-1:0] cke_a;
        logic [CTL_W-1:0] cke_b;
        logic [CTL_W-1:0] odt_a;
        logic [CTL_W-1:0] odt_b;
    } ctl_state_t;

    ctl_state_t st_d, st_q;

    always_comb begin
        if (rst) begin
            st_d = '0;
        end else begin
            st_d.cke_a = cke_in;
            st_d.cke_b = cke_in;
            st_d.odt_a = odt_in;
            st_d.odt_b = odt_in;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cke_a_o = st_q.cke_a;
    assign cke_b_o = st_q.cke_b;
    assign odt_a_o = st_q.odt_a;
    assign odt_b_o = st_q.odt_b;

    AST_CTL_RESET: assert property (@(posedge clk)
        rst |=> cke_a_o == '0 && cke_b_o == '0 && odt_a_o == '0 && odt_b_o == '0); // R6

    AST_CTL_PASS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> cke_a_o == $past(cke_in) && cke_b_o == $past(cke_in) &&
                 odt_a_o == $past(odt_in) && odt_b_o == $past(odt_in)); // R7
endmodule

// File: rtl/csg_cmd_register.sv
module csg_cmd_register
    import csg_pkg::*;
#(
    parameter int CA_W  = 24,
    parameter int CTL_W = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 dual_mode_pin,
    input  logic [CS_IN_W-1:0]   cs_n_in,
    input  logic [CA_W-1:0]      ca_in,
    input  logic [CTL_W-1:0]     cke_in,
    input  logic [CTL_W-1:0]     odt_in,
    output logic [CA_W-1:0]      ca_a,
    output logic [CA_W-1:0]      ca_b,
    output logic [CS_SIDE_W-1:0] cs_a_n,
    output logic [CS_SIDE_W-1:0] cs_b_n,
    output logic [CTL_W-1:0]     cke_a,
    output logic [CTL_W-1:0]     cke_b,
    output logic [CTL_W-1:0]     odt_a,
    output logic [CTL_W-1:0]     odt_b
);
    logic any_sel;

    csg_cs_router u_cs (
        .clk           (clk),
        .rst           (rst),
        .dual_mode_pin (dual_mode_pin),
        .cs_n_in       (cs_n_in),
        .cs_a_n_o      (cs_a_n),
        .cs_b_n_o      (cs_b_n),
        .any_sel_o     (any_sel)
    );

    csg_ca_stage #(.CA_W(CA_W)) u_ca (
        .clk    (clk),
        .rst    (rst),
        .load   (any_sel),
        .ca_in  (ca_in),
        .ca_a_o (ca_a),
        .ca_b_o (ca_b)
    );

    csg_ctl_stage #(.CTL_W(CTL_W)) u_ctl (
        .clk     (clk),
        .rst     (rst),
        .cke_in  (cke_in),
        .odt_in  (odt_in),
        .cke_a_o (cke_a),
        .cke_b_o (cke_b),
        .odt_a_o (odt_a),
        .odt_b_o (odt_b)
    );

    AST_SIDES_AGREE_CA: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ca_a == ca_b); // R2
endmodule

// File: tb/csg_cmd_register_tb.sv
`timescale 1ns/1ps
module csg_cmd_register_tb;
    localparam int CA_W  = 16;
    localparam int CTL_W = 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             dual_mode_pin = 1'b1;
    logic [3:0]       cs_n_in = 4'hF;
    logic [CA_W-1:0]  ca_in = '0;
    logic [CTL_W-1:0] cke_in = '0;
    logic [CTL_W-1:0] odt_in = '0;
    logic [CA_W-1:0]  ca_a, ca_b;
    logic [1:0]       cs_a_n, cs_b_n;
    logic [CTL_W-1:0] cke_a, cke_b, odt_a, odt_b;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    csg_cmd_register #(.CA_W(CA_W), .CTL_W(CTL_W)) u_dut (
        .clk(clk), .rst(rst), .dual_mode_pin(dual_mode_pin), .cs_n_in(cs_n_in),
        .ca_in(ca_in), .cke_in(cke_in), .odt_in(odt_in),
        .ca_a(ca_a), .ca_b(ca_b), .cs_a_n(cs_a_n), .cs_b_n(cs_b_n),
        .cke_a(cke_a), .cke_b(cke_b), .odt_a(odt_a), .odt_b(odt_b)
    );

    typedef struct packed {
        logic [3:0]  cs;
        logic [15:0] ca;
        logic [1:0]  cke;
        logic [1:0]  odt;
        logic [15:0] exp_ca;
    } vec_t;

    // Dual mode: only cs[1:0] count.
    localparam vec_t VEC [8] = '{
        '{4'b1111, 16'h1111, 2'b00, 2'b11, 16'h0000},  // R5 hold reset value
        '{4'b1110, 16'hA5A5, 2'b01, 2'b10, 16'hA5A5},  // R2 load
        '{4'b1111, 16'hFFFF, 2'b10, 2'b01, 16'hA5A5},  // R5 hold
        '{4'b1101, 16'h1234, 2'b11, 2'b00, 16'h1234},  // R2 load
        '{4'b0011, 16'h5555, 2'b00, 2'b01, 16'h1234},  // R3 upper ignored
        '{4'b1100, 16'hBEEF, 2'b11, 2'b11, 16'hBEEF},  // R2 both low
        '{4'b0111, 16'h7777, 2'b01, 2'b00, 16'hBEEF},  // R3 upper ignored
        '{4'b1110, 16'h0F0F, 2'b10, 2'b10, 16'h0F0F}   // R2 load
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_idle(input string tag);
        chk({tag, " cs_a_n"}, 32'(cs_a_n), 32'h3);
        chk({tag, " cs_b_n"}, 32'(cs_b_n), 32'h3);
        chk({tag, " ca_a"},   32'(ca_a),   32'h0);
        chk({tag, " ca_b"},   32'(ca_b),   32'h0);
        chk({tag, " cke"},    32'({cke_a, cke_b}), 32'h0);
        chk({tag, " odt"},    32'({odt_a, odt_b}), 32'h0);
    endtask

    task automatic step(input logic [3:0] cs, input logic [15:0] ca,
                        input logic [1:0] ck, input logic [1:0] od);
        @(negedge clk);
        cs_n_in = cs; ca_in = ca; cke_in = ck; odt_in = od;
        @(posedge clk);
        #1;
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        // Reset with busy inputs: outputs must be idle.
        cs_n_in = 4'b0000; ca_in = 16'hFFFF; cke_in = 2'b11; odt_in = 2'b11;
        repeat (2) @(posedge clk);
        #1;
        chk_idle("R6 reset dual");

        @(negedge clk);
        rst = 1'b0;
        cs_n_in = 4'hF; ca_in = '0; cke_in = '0; odt_in = '0;

        for (int i = 0; i < 8; i++) begin
            step(VEC[i].cs, VEC[i].ca, VEC[i].cke, VEC[i].odt);
            chk("R2 R5 R3 ca_a", 32'(ca_a), 32'(VEC[i].exp_ca));
            chk("R2 R5 R3 ca_b", 32'(ca_b), 32'(VEC[i].exp_ca));
            chk("R3 cs_a_n", 32'(cs_a_n), 32'(VEC[i].cs[1:0]));
            chk("R3 cs_b_n", 32'(cs_b_n), 32'(VEC[i].cs[1:0]));
            chk("R7 cke", 32'({cke_a, cke_b}), 32'({VEC[i].cke, VEC[i].cke}));
            chk("R7 odt", 32'({odt_a, odt_b}), 32'({VEC[i].odt, VEC[i].odt}));
        end

        // R1: outputs do not follow inputs between edges.
        @(negedge clk);
        cs_n_in = 4'b1110; ca_in = 16'h4242; cke_in = 2'b01; odt_in = 2'b01;
        #1;
        chk("R1 ca_a before edge", 32'(ca_a), 32'h0F0F);
        chk("R1 cke_a before edge", 32'(cke_a), 32'h2);
        @(posedge clk);
        #1;
        chk("R1 ca_a after edge", 32'(ca_a), 32'h4242);
        chk("R1 cke_a after edge", 32'(cke_a), 32'h1);

        // Reset into quad mode.
        @(negedge clk);
        rst = 1'b1; dual_mode_pin = 1'b0;
        cs_n_in = 4'b0000; ca_in = 16'h9999; cke_in = 2'b11; odt_in = 2'b10;
        @(posedge clk);
        #1;
        chk_idle("R6 reset quad");
        @(negedge clk);
        rst = 1'b0;

        step(4'b1011, 16'hCAFE, 2'b10, 2'b00);
        chk("R4 ca_a via cs2", 32'(ca_a), 32'hCAFE);
        chk("R4 cs_a_n", 32'(cs_a_n), 32'h3);
        chk("R4 cs_b_n", 32'(cs_b_n), 32'h2);

        step(4'b0111, 16'h1357, 2'b01, 2'b11);
        chk("R4 ca_b via cs3", 32'(ca_b), 32'h1357);
        chk("R4 cs_b_n", 32'(cs_b_n), 32'h1);
        chk("R7 cke quad", 32'({cke_a, cke_b}), 32'h5);

        step(4'b1111, 16'h0000, 2'b00, 2'b00);
        chk("R5 quad hold ca_a", 32'(ca_a), 32'h1357);
        chk("R4 cs idle", 32'({cs_b_n, cs_a_n}), 32'hF);

        // R8: pin changes outside reset; quad mapping must persist.
        @(negedge clk);
        dual_mode_pin = 1'b1;
        step(4'b0111, 16'h2468, 2'b00, 2'b00);
        chk("R8 still quad ca_a", 32'(ca_a), 32'h2468);
        chk("R8 still quad cs_b_n", 32'(cs_b_n), 32'h1);
        step(4'b1101, 16'h3690, 2'b00, 2'b00);
        chk("R8 still quad cs_b_n", 32'(cs_b_n), 32'h3);
        chk("R8 cs_a_n", 32'(cs_a_n), 32'h1);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule